// File: doc/BRIEF.md
# One-Time-Programmable Memory Access Controller

This block stands between an external programming port and an on-chip model of one-time-programmable storage. A request names an operation (program or verify), a region and a byte address. The block checks the address against the region size. It then applies a cumulative three-level lock policy to decide whether the operation may go ahead. A program operation that passes the checks fires exactly one timed write pulse. When the pulse ends, the byte is committed with one-time-programmable semantics: bits can only go from 1 to 0. A verify operation returns the stored byte. Code bytes are returned masked by a 32-byte key array, and an erased key passes the data through unchanged.

Requests use a valid/ready handshake. `req_ready` is high only when no pulse is running and no response is waiting to be taken. While it is low, the request pins are ignored. Each accepted request produces exactly one response. The response stays on `rsp_valid`, `rsp_data` and `rsp_err`, unchanged, until `rsp_ready` is seen high at a clock edge; this is how the requester applies back-pressure. The level-three lock also drives a plain `ext_exec_en` output that permits fetches from external memory. Reset returns the storage model to its erased state, standing in for a fresh part.

Top module: `otp_access_ctrl`

## Requirements
- R1: After reset, every stored byte (code, configuration, lock, key) reads 0xFF, `req_ready` is 1, `rsp_valid` is 0, `prog_pulse` is 0 and `ext_exec_en` is 1.
- R2: An accepted program operation leaves the target byte equal to the old value AND the write data. The response data is that new value with `rsp_err` 0. A programmed 0 never returns to 1.
- R3: Each accepted program operation raises `prog_pulse` for exactly PULSE_CYCLES = (CLK_HZ/1e6)·PULSE_US consecutive cycles (at least 1), once and with no retry. The response follows in the cycle after the pulse ends. A rejected operation raises no pulse.
- R4: While `req_ready` is 0 (pulse running or response pending), `req_valid` and the request fields are ignored: nothing is accepted and no memory changes.
- R5: Region codes are 0 code, 1 configuration, 2 lock byte, 3 key array and 4 signature. Lock byte bits 0, 1 and 2 are lock bits 1, 2 and 3, and a bit is set when it is programmed to 0. With level 1 active, program operations to code, configuration and key are rejected (`rsp_err` 1, data 0x00) and the memory is unchanged.
- R6: With level 2 active, code verify is rejected. Configuration and lock byte verify always succeed, whatever the level.
- R7: Key array verify is always rejected with `rsp_err` 1 and data 0x00.
- R8: `ext_exec_en` is 0 exactly while level 3 is active.
- R9: Code verify returns ~(code[a] ^ key[a mod 32]).
- R10: The signature region is read-only. Verify of address a below SIG_DEPTH returns SIG_ID ^ a. Any program operation to it is rejected.
- R11: An address outside its region (configuration ≥ CFG_DEPTH, lock ≠ 0, key ≥ KEY_DEPTH, signature ≥ SIG_DEPTH), or a region code above 4, is rejected with no effect.
- R12: While `rsp_valid` is 1 and `rsp_ready` is 0, the response stays valid and its data and error are stable.
- R13: Levels are cumulative. Level n is active only when lock bits 1 through n are all 0. A higher bit programmed alone activates no level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; erases the storage model |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = program, 0 = verify |
| req_region | input | 3 | Region code (0 code, 1 configuration, 2 lock, 3 key, 4 signature) |
| req_addr | input | CODE_AW | Byte address within the region |
| req_wdata | input | 8 | Program data; zeros select bits to program |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_data | output | 8 | Verify data or newly stored byte; 0x00 on error |
| rsp_err | output | 1 | Operation rejected |
| prog_pulse | output | 1 | Write pulse to the storage |
| ext_exec_en | output | 1 | External execution permitted |

## Verification
A lock byte commit at the end of a pulse lands in the same cycle as the response strobe. The very next request must then be judged under the new lock level. The bench provokes this by following each lock program at once with a full sweep over every region and address. Each result is compared against an arithmetic model whose lock level was updated by that commit, and `ext_exec_en` is checked alongside. A second overlap sets a new request on the pins while the pulse of an accepted one is still running and while its response is held back. The bench judges this by the held response staying stable and by a later verify showing that the untouched byte is unchanged.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [2:0] {
    RG_CODE = 3'd0,
    RG_CFG  = 3'd1,
    RG_LOCK = 3'd2,
    RG_KEY  = 3'd3,
    RG_SIG  = 3'd4
  } region_e;

  typedef struct packed {
    logic lvl1;
    logic lvl2;
    logic lvl3;
  } lock_lvl_t;
endpackage

// File: rtl/otp_lock_policy.sv
module otp_lock_policy
  import otp_pkg::*;
(
  input  logic [2:0] lock_bits,
  input  logic       is_write,
  input  logic [2:0] region,
  input  logic       addr_ok,
  output lock_lvl_t  lvl,
  output logic       allow
);
  always_comb begin
    lvl.lvl1 = ~lock_bits[0];
    lvl.lvl2 = ~lock_bits[0] & ~lock_bits[1];
    lvl.lvl3 = ~lock_bits[0] & ~lock_bits[1] & ~lock_bits[2];
  end

  always_comb begin
    case (region_e'(region))
      RG_CODE: allow = is_write ? ~lvl.lvl1 : ~lvl.lvl2;
      RG_CFG:  allow = is_write ? ~lvl.lvl1 : 1'b1;
      RG_LOCK: allow = 1'b1;
      RG_KEY:  allow = is_write ? ~lvl.lvl1 : 1'b0;
      RG_SIG:  allow = ~is_write;
      default: allow = 1'b0;
    endcase
    allow = allow & addr_ok;
  end
endmodule

// File: rtl/otp_pulse_timer.sv
module otp_pulse_timer #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= CW'(CYCLES - 1);
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assign done = active && (cnt == '0);
endmodule

// File: rtl/otp_store.sv
module otp_store #(
  parameter int DEPTH = 4,
  parameter int AW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0] cells [DEPTH];
  logic [IW-1:0] widx, ridx;

  assign widx = IW'(waddr);
  assign ridx = IW'(raddr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
    end else if (we && (int'(waddr) < DEPTH)) begin
      cells[widx] <= cells[widx] & wdata;
    end
  end

  assign rdata = (int'(raddr) < DEPTH) ? cells[ridx] : 8'hFF;
endmodule

// File: rtl/otp_access_ctrl.sv
module otp_access_ctrl
  import otp_pkg::*;
#(
  parameter int         CLK_HZ    = 125_000_000,
  parameter int         PULSE_US  = 100,
  parameter int         CODE_AW   = 6,
  parameter int         CFG_DEPTH = 4,
  parameter int         KEY_DEPTH = 32,
  parameter int         SIG_DEPTH = 4,
  parameter logic [7:0] SIG_ID    = 8'h5A
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [2:0]         req_region,
  input  logic [CODE_AW-1:0] req_addr,
  input  logic [7:0]         req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [7:0]         rsp_data,
  output logic               rsp_err,
  output logic               prog_pulse,
  output logic               ext_exec_en
);
  localparam int CODE_DEPTH   = 1 << CODE_AW;
  localparam int KEY_AW       = $clog2(KEY_DEPTH);
  localparam int PULSE_RAW    = (CLK_HZ / 1_000_000) * PULSE_US;
  localparam int PULSE_CYCLES = (PULSE_RAW < 1) ? 1 : PULSE_RAW;

  logic               pulse_active, pulse_done, start, accept, allow, addr_ok;
  logic [2:0]         lat_region, sel_region;
  logic [CODE_AW-1:0] lat_addr, sel_addr;
  logic [7:0]         lat_wdata;
  logic [7:0]         lock_q;
  logic [7:0]         code_rd, cfg_rd, key_rd, raw_rd, verify_rd;
  logic               code_we, cfg_we, key_we, lock_we;
  logic               rsp_valid_q, rsp_err_q;
  logic [7:0]         rsp_data_q;
  lock_lvl_t          lvl;

  assign req_ready = !pulse_active && !rsp_valid_q;
  assign accept    = req_valid && req_ready;

  assign sel_addr   = pulse_active ? lat_addr   : req_addr;
  assign sel_region = pulse_active ? lat_region : req_region;

  always_comb begin
    case (region_e'(sel_region))
      RG_CODE: addr_ok = 1'b1;
      RG_CFG:  addr_ok = int'(sel_addr) < CFG_DEPTH;
      RG_LOCK: addr_ok = sel_addr == '0;
      RG_KEY:  addr_ok = int'(sel_addr) < KEY_DEPTH;
      RG_SIG:  addr_ok = int'(sel_addr) < SIG_DEPTH;
      default: addr_ok = 1'b0;
    endcase
  end

  otp_lock_policy u_policy (
    .lock_bits (lock_q[2:0]),
    .is_write  (req_write),
    .region    (req_region),
    .addr_ok   (addr_ok),
    .lvl       (lvl),
    .allow     (allow)
  );

  assign start = accept && req_write && allow;

  otp_pulse_timer #(.CYCLES(PULSE_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .active (pulse_active),
    .done   (pulse_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_region <= '0;
      lat_addr   <= '0;
      lat_wdata  <= 8'hFF;
    end else if (start) begin
      lat_region <= req_region;
      lat_addr   <= req_addr;
      lat_wdata  <= req_wdata;
    end
  end

  assign code_we = pulse_done && (region_e'(lat_region) == RG_CODE);
  assign cfg_we  = pulse_done && (region_e'(lat_region) == RG_CFG);
  assign key_we  = pulse_done && (region_e'(lat_region) == RG_KEY);
  assign lock_we = pulse_done && (region_e'(lat_region) == RG_LOCK);

  otp_store #(.DEPTH(CODE_DEPTH), .AW(CODE_AW)) u_code (
    .clk (clk), .rst_n (rst_n), .we (code_we), .waddr (lat_addr),
    .wdata (lat_wdata), .raddr (sel_addr), .rdata (code_rd)
  );

  otp_store #(.DEPTH(CFG_DEPTH), .AW(CODE_AW)) u_cfg (
    .clk (clk), .rst_n (rst_n), .we (cfg_we), .waddr (lat_addr),
    .wdata (lat_wdata), .raddr (sel_addr), .rdata (cfg_rd)
  );

  otp_store #(.DEPTH(KEY_DEPTH), .AW(KEY_AW)) u_key (
    .clk (clk), .rst_n (rst_n), .we (key_we), .waddr (lat_addr[KEY_AW-1:0]),
    .wdata (lat_wdata), .raddr (sel_addr[KEY_AW-1:0]), .rdata (key_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_q <= 8'hFF;
    else if (lock_we) lock_q <= lock_q & lat_wdata;
  end

  always_comb begin
    case (region_e'(sel_region))
      RG_CODE: raw_rd = code_rd;
      RG_CFG:  raw_rd = cfg_rd;
      RG_LOCK: raw_rd = lock_q;
      RG_KEY:  raw_rd = key_rd;
      RG_SIG:  raw_rd = SIG_ID ^ 8'(sel_addr);
      default: raw_rd = 8'h00;
    endcase
    verify_rd = (region_e'(sel_region) == RG_CODE) ? ~(code_rd ^ key_rd) : raw_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_data_q  <= 8'h00;
    end else if (rsp_valid_q) begin
      if (rsp_ready) rsp_valid_q <= 1'b0;
    end else if (pulse_done) begin
      rsp_valid_q <= 1'b1;
      rsp_err_q   <= 1'b0;
      rsp_data_q  <= raw_rd & lat_wdata;
    end else if (accept && !start) begin
      rsp_valid_q <= 1'b1;
      rsp_err_q   <= !allow;
      rsp_data_q  <= allow ? verify_rd : 8'h00;
    end
  end

  assign rsp_valid   = rsp_valid_q;
  assign rsp_err     = rsp_err_q;
  assign rsp_data    = rsp_data_q;
  assign prog_pulse  = pulse_active;
  assign ext_exec_en = !lvl.lvl3;
endmodule

// File: rtl/otp_access_ctrl_chk.sv
module otp_access_ctrl_chk #(
  parameter int PULSE_CYCLES = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       prog_pulse,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_data,
  input logic       rsp_err,
  input logic       ext_exec_en,
  input logic [7:0] lock_q
);
  int plen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          plen <= 0;
    else if (prog_pulse) plen <= plen + 1;
    else                 plen <= 0;
  end

  // R3
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_pulse) |-> (plen == PULSE_CYCLES));

  // R3
  pulse_then_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_pulse) |-> (rsp_valid && !rsp_err));

  // R4
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_pulse |-> !req_ready);

  // R12
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err)));

  // R2
  lock_otp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q & ~$past(lock_q)) == 8'h00);

  // R8
  exec_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_exec_en |=> !ext_exec_en);
endmodule

bind otp_access_ctrl otp_access_ctrl_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .prog_pulse  (prog_pulse),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_data    (rsp_data),
  .rsp_err     (rsp_err),
  .ext_exec_en (ext_exec_en),
  .lock_q      (lock_q)
);

// File: tb/otp_access_ctrl_test.sv
module otp_access_ctrl_test;
  localparam int P = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [2:0] req_region = '0;
  logic [5:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       req_ready, rsp_valid, rsp_err, prog_pulse, ext_exec_en;
  logic [7:0] rsp_data;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done_flag = 0;

  logic [7:0] m_code [64];
  logic [7:0] m_cfg  [4];
  logic [7:0] m_key  [32];
  logic [7:0] m_lock;

  otp_access_ctrl #(.CLK_HZ(4_000_000), .PULSE_US(1)) uut (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
    .req_write (req_write), .req_region (req_region), .req_addr (req_addr),
    .req_wdata (req_wdata), .rsp_valid (rsp_valid), .rsp_ready (rsp_ready),
    .rsp_data (rsp_data), .rsp_err (rsp_err), .prog_pulse (prog_pulse),
    .ext_exec_en (ext_exec_en)
  );

  always #4 clk = ~clk;

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done_flag) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      done_flag = 1;
      report();
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit lv(int n);
    bit r = 1;
    for (int i = 0; i < n; i++) r &= ~m_lock[i];
    return r;
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < 64; i++) m_code[i] = 8'hFF;
    for (int i = 0; i < 32; i++) m_key[i] = 8'hFF;
    for (int i = 0; i < 4; i++) m_cfg[i] = 8'hFF;
    m_lock = 8'hFF;
  endfunction

  function automatic void model(bit w, int rg, int a, logic [7:0] d,
                                output logic [7:0] ed, output bit ee);
    ee = 1; ed = 8'h00;
    case (rg)
      0: if (w) begin
           if (!lv(1)) begin m_code[a] &= d; ed = m_code[a]; ee = 0; end
         end else if (!lv(2)) begin
           ed = ~(m_code[a] ^ m_key[a % 32]); ee = 0;
         end
      1: if (a < 4) begin
           if (w) begin
             if (!lv(1)) begin m_cfg[a] &= d; ed = m_cfg[a]; ee = 0; end
           end else begin ed = m_cfg[a]; ee = 0; end
         end
      2: if (a == 0) begin
           if (w) m_lock &= d;
           ed = m_lock; ee = 0;
         end
      3: if (w && !lv(1) && a < 32) begin m_key[a] &= d; ed = m_key[a]; ee = 0; end
      4: if (!w && a < 4) begin ed = 8'h5A ^ 8'(a); ee = 0; end
      default: ;
    endcase
  endfunction

  task automatic xfer(bit w, int rg, int a, logic [7:0] d,
                      output logic [7:0] rd, output bit e, output int pc);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = w; req_region = 3'(rg); req_addr = 6'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    pc = 0;
    while (!rsp_valid) begin
      if (prog_pulse) pc++;
      @(negedge clk);
    end
    rd = rsp_data; e = rsp_err;
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  task automatic op(bit w, int rg, int a, logic [7:0] d, string tag);
    logic [7:0] ed, rd; bit ee, e; int pc;
    model(w, rg, a, d, ed, ee);
    xfer(w, rg, a, d, rd, e, pc);
    check(tag, {e, rd}, {ee, ed});
    if (w) check("R3 pulse count", pc, ee ? 0 : P);
  endtask

  task automatic sweep();
    string t;
    for (int rg = 0; rg < 8; rg++)
      for (int a = 0; a < 64; a++) begin
        case (rg)
          0: t = "R9 R6 code verify";
          1: t = "R6 cfg verify";
          2: t = "R6 lock verify";
          3: t = "R7 key verify";
          4: t = "R10 sig verify";
          default: t = "R11 bad region";
        endcase
        op(0, rg, a, 8'h00, t);
      end
  endtask

  task automatic exec_chk();
    @(negedge clk);
    check("R8 ext_exec_en", ext_exec_en, !lv(3));
  endtask

  task automatic do_reset();
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 req_ready", req_ready, 1);
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 prog_pulse", prog_pulse, 0);
    check("R1 ext_exec_en", ext_exec_en, 1);
  endtask

  initial begin
    logic [7:0] cap, ed; bit cape, ee;
    do_reset();
    sweep();
    // R2 program then AND a second pattern
    for (int a = 0; a < 64; a++) op(1, 0, a, 8'(a * 37 + 5), "R2 code program");
    for (int a = 0; a < 64; a += 3) op(1, 0, a, ~8'(a * 11), "R2 AND program");
    for (int a = 0; a < 4; a++) op(1, 1, a, 8'(8'hF0 | a), "R2 cfg program");
    op(1, 3, 40, 8'h00, "R11 key out of range");
    op(1, 4, 0, 8'h00, "R10 sig write");
    op(1, 1, 9, 8'h00, "R11 cfg out of range");
    op(1, 2, 1, 8'h00, "R11 lock addr");
    sweep();
    for (int a = 0; a < 32; a++) op(1, 3, a, 8'(a * 13 + 1), "R9 key program");
    sweep();

    // R4 / R12: new request held during pulse, response held back
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 1; req_region = 3'd0; req_addr = 6'd10; req_wdata = 8'h0F;
    @(negedge clk);
    req_addr = 6'd11; req_wdata = 8'h00;
    while (!rsp_valid) begin
      check("R4 not ready", req_ready, 0);
      @(negedge clk);
    end
    cap = rsp_data; cape = rsp_err;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R12 held valid", rsp_valid, 1);
      check("R12 held data", {rsp_err, rsp_data}, {cape, cap});
      check("R4 not ready", req_ready, 0);
    end
    req_valid = 0;
    rsp_ready = 1; @(negedge clk); rsp_ready = 0;
    model(1, 0, 10, 8'h0F, ed, ee);
    check("R2 held program", {cape, cap}, {ee, ed});
    op(0, 0, 11, 8'h00, "R4 ignored write");

    // R13 level 1 only
    op(1, 2, 0, 8'hFE, "R13 lock bit1");
    exec_chk();
    op(1, 0, 5, 8'h00, "R5 code program locked");
    op(1, 1, 2, 8'h00, "R5 cfg program locked");
    op(1, 3, 3, 8'h00, "R5 key program locked");
    op(0, 0, 5, 8'h00, "R5 code verify open");
    op(1, 2, 0, 8'hFB, "R13 lock bit3 alone");
    exec_chk();
    sweep();
    op(1, 2, 0, 8'hFD, "R13 lock bit2");
    exec_chk();
    op(1, 2, 0, 8'hFF, "R2 lock no rise");
    sweep();

    // level 2 without level 3
    do_reset();
    sweep();
    op(1, 0, 7, 8'h3C, "R2 code program");
    op(1, 2, 0, 8'hFD, "R13 bit2 alone");
    exec_chk();
    op(1, 0, 8, 8'h55, "R13 code program open");
    op(1, 2, 0, 8'hFE, "R13 level2");
    exec_chk();
    sweep();
    op(1, 2, 0, 8'hFB, "R8 level3");
    exec_chk();
    sweep();

    done_flag = 1;
    report();
  end
endmodule